// File: doc/BRIEF.md
# Serial Lane Protocol Switch Sequencer

This block moves one serial lane from its current line protocol and speed to a new one. A request names a lane and a target mode code. The sequencer then drives a fixed, ordered list of register field writes and reads over a one-at-a-time internal access port, with one field per access. It hands PLL selection and clock-ready qualification to companion blocks through request/done handshakes. When the sequence ends it raises a one-cycle completion strobe together with three error flags. Each flag stays valid until the next request is accepted.

The two slow modes and the two mid-speed modes need only the basic sequence. The 10 Gb/s mode adds a link check. Loopback is forced on, and the lane's reset bit is pulsed while a latched link bit is polled, up to a parameterised number of attempts. Afterwards the original loopback setting is put back and one more reset pulse follows. Every hold period is a whole number of milliseconds, counted in clock cycles per millisecond, so a bench can shrink the timing.

FSM states: `S_IDLE`, `S_PWR_DN`, `S_OFF_FEN`, `S_OFF_MODE`, `S_PLL`, `S_NEW_FEN`, `S_NEW_MODE`, `S_CLK`, `S_LB_SAVE`, `S_LB_ON`, `S_SMR_SET`, `S_SMR_HI`, `S_SMR_CLR`, `S_SMR_LO`, `S_LINK_RD1`, `S_LINK_RD2`, `S_LB_RESTORE`, `S_PWR_UP`, `S_RX_SET`, `S_RX_CLR`, `S_DONE`.

Each access state leaves on the cycle its access is acknowledged:
- `S_PLL` leaves on `pll_done` and `S_CLK` leaves on `clk_done`.
- The two hold states leave when the timer expires.
- `S_OFF_MODE` goes to `S_DONE` for the off mode and to `S_PLL` otherwise.
- `S_CLK` goes to `S_LB_SAVE` for 10 Gb/s and to `S_PWR_UP` otherwise.
- `S_SMR_LO` goes to `S_PWR_UP` after the closing pulse and to `S_LINK_RD1` otherwise.
- `S_LINK_RD2` goes to `S_LB_RESTORE` when the link bit reads 1 or the attempts are used up, and back to `S_SMR_SET` otherwise.
- `S_LB_RESTORE` goes to `S_SMR_SET` for the closing pulse.
- `S_DONE` returns to `S_IDLE`.

Top module: `serdes_reconfig_seq`

## Requirements
- R1: After reset the block is idle. In that state `req_ready` is 1 and `acc_valid`, `pll_req`, `clk_req`, `done` and `req_rej` are all 0.
- R2: Request codes are 0 off, 1 SGMII, 2 1000BASE-X, 3 HSGMII, 4 2500BASE-X and 5 10GBASE-R. Codes 6 and 7 pulse `req_rej` on the cycle after the request and start no access or handshake.
- R3: Field codes are 0 power (2 bits), 1 force-mode enable, 2 mode (5 bits), 3 loopback, 4 state-machine reset, 5 latched link (read) and 6 receive reset. A non-off request runs the following steps, in this order:
  1. power←3
  2. enable←1
  3. mode←0x1F
  4. PLL handshake
  5. enable←1
  6. mode←target
  7. clock-ready handshake
  8. the 10 Gb/s check, for 10 Gb/s only
  9. power←0
  10. receive reset←1
  11. receive reset←0
  12. `done`
- R4: An off request stops after power←3, enable←1 and mode←0x1F, then raises `done`. It makes no PLL or clock-ready request.
- R5: Target mode field values are SGMII 0x02, 1000BASE-X 0x04, HSGMII 0x12, 2500BASE-X 0x16 and 10GBASE-R 0x1A. The PLL speed code is 1 for the two 1G modes, 3 for the two 2.5G modes and 5 for 10G.
- R6: The 10 Gb/s check first reads loopback and writes loopback←1. Each attempt is then: reset←1, hold, reset←0, hold, and two reads of the link bit, of which only the second decides.
- R7: The check stops at the first attempt whose second link read is 1. It gives up after LINK_TRIES attempts.
- R8: After the check, loopback is written back with the value read at its start, and one more reset pulse with both holds follows. This happens whether the check passed or failed.
- R9: A PLL error, a clock-ready timeout and a failed link check each set their own flag (`err_pll`, `err_clk`, `err_link`) at `done`. None of them stops the sequence.
- R10: While `acc_valid` is high and `acc_ready` is low, lane, field, write flag and write data hold steady.
- R11: A request made while a sequence is running is ignored, and `req_ready` is 0 during that time.
- R12: Each hold after a reset write lasts at least HOLD_MS × CYC_PER_MS cycles before the next access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request strobe |
| req_lane | input | LANE_W | Target lane index |
| req_mode | input | 3 | Requested mode code |
| req_ready | output | 1 | Idle, request may be taken |
| req_rej | output | 1 | Unsupported code rejected |
| done | output | 1 | Sequence complete strobe |
| err_pll | output | 1 | PLL configuration failed |
| err_clk | output | 1 | Clock-ready timeout |
| err_link | output | 1 | 10G link check failed |
| acc_valid | output | 1 | Register access request |
| acc_write | output | 1 | 1 write, 0 read |
| lane_sel | output | LANE_W | Lane for access and handshakes |
| acc_field | output | 3 | Field code |
| acc_wdata | output | 5 | Write value |
| acc_ready | input | 1 | Access acknowledge |
| acc_rdata | input | 1 | Read value (bit 0 of field) |
| pll_req | output | 1 | PLL configuration request |
| pll_speed | output | 3 | Speed code for PLL |
| pll_done | input | 1 | PLL configuration finished |
| pll_err | input | 1 | PLL configuration failed |
| clk_req | output | 1 | Clock-ready wait request |
| clk_done | input | 1 | Clock-ready wait finished |
| clk_timeout | input | 1 | Clock never qualified |

## Verification
The bench builds the block with four lanes, two cycles per millisecond, a three-millisecond hold and four link attempts. With these values each hold lasts six cycles, so the hold-length check is quick. A 10 Gb/s run that never sees a link reaches its attempt limit, and the error path that follows it runs in a few hundred cycles. The modelled link register reads 0 on the first read of each pair. This exposes any design that acts on the stale latched value instead of the second read.

// File: rtl/serdes_reconfig_pkg.sv
package serdes_reconfig_pkg;

    localparam int FIELD_W = 3;
    localparam int WDATA_W = 5;
    localparam int SPEED_W = 3;
    localparam int CODE_W  = 3;

    // field codes on the access port
    localparam logic [FIELD_W-1:0] FLD_PWR   = 3'd0;
    localparam logic [FIELD_W-1:0] FLD_FEN   = 3'd1;
    localparam logic [FIELD_W-1:0] FLD_MODE  = 3'd2;
    localparam logic [FIELD_W-1:0] FLD_LPBK  = 3'd3;
    localparam logic [FIELD_W-1:0] FLD_SMRST = 3'd4;
    localparam logic [FIELD_W-1:0] FLD_LINK  = 3'd5;
    localparam logic [FIELD_W-1:0] FLD_RXRST = 3'd6;

    // request codes
    localparam logic [CODE_W-1:0] REQ_OFF   = 3'd0;
    localparam logic [CODE_W-1:0] REQ_SGMII = 3'd1;
    localparam logic [CODE_W-1:0] REQ_1GX   = 3'd2;
    localparam logic [CODE_W-1:0] REQ_HSG   = 3'd3;
    localparam logic [CODE_W-1:0] REQ_2G5X  = 3'd4;
    localparam logic [CODE_W-1:0] REQ_10GR  = 3'd5;

    // internal mode field values
    localparam logic [WDATA_W-1:0] MSEL_OFF   = 5'h1F;
    localparam logic [WDATA_W-1:0] MSEL_SGMII = 5'h02;
    localparam logic [WDATA_W-1:0] MSEL_1GX   = 5'h04;
    localparam logic [WDATA_W-1:0] MSEL_HSG   = 5'h12;
    localparam logic [WDATA_W-1:0] MSEL_2G5X  = 5'h16;
    localparam logic [WDATA_W-1:0] MSEL_10GR  = 5'h1A;

    // PLL speed codes
    localparam logic [SPEED_W-1:0] SPD_1G   = 3'd1;
    localparam logic [SPEED_W-1:0] SPD_2G5  = 3'd3;
    localparam logic [SPEED_W-1:0] SPD_10G  = 3'd5;

    localparam logic [WDATA_W-1:0] PWR_DOWN_VAL = 5'd3;
    localparam logic [WDATA_W-1:0] PWR_UP_VAL   = 5'd0;

    typedef enum logic [4:0] {
        S_IDLE, S_PWR_DN, S_OFF_FEN, S_OFF_MODE, S_PLL,
        S_NEW_FEN, S_NEW_MODE, S_CLK, S_LB_SAVE, S_LB_ON,
        S_SMR_SET, S_SMR_HI, S_SMR_CLR, S_SMR_LO, S_LINK_RD1,
        S_LINK_RD2, S_LB_RESTORE, S_PWR_UP, S_RX_SET, S_RX_CLR,
        S_DONE
    } seq_state_e;

endpackage

// File: rtl/seq_mode_decode.sv
module seq_mode_decode
    import serdes_reconfig_pkg::*;
(
    input  logic [CODE_W-1:0]  code,
    output logic               supported,
    output logic               is_off,
    output logic               is_10g,
    output logic [WDATA_W-1:0] mode_sel,
    output logic [SPEED_W-1:0] speed
);

    always_comb begin
        supported = 1'b1;
        is_off    = 1'b0;
        is_10g    = 1'b0;
        mode_sel  = MSEL_OFF;
        speed     = SPD_1G;
        case (code)
            REQ_OFF: begin
                is_off = 1'b1;
            end
            REQ_SGMII: begin
                mode_sel = MSEL_SGMII;
                speed    = SPD_1G;
            end
            REQ_1GX: begin
                mode_sel = MSEL_1GX;
                speed    = SPD_1G;
            end
            REQ_HSG: begin
                mode_sel = MSEL_HSG;
                speed    = SPD_2G5;
            end
            REQ_2G5X: begin
                mode_sel = MSEL_2G5X;
                speed    = SPD_2G5;
            end
            REQ_10GR: begin
                mode_sel = MSEL_10GR;
                speed    = SPD_10G;
                is_10g   = 1'b1;
            end
            default: begin
                supported = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/seq_hold_timer.sv
module seq_hold_timer #(
    parameter int CYC_PER_MS = 200000,
    parameter int HOLD_MS    = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);

    localparam int LIMIT = CYC_PER_MS * HOLD_MS;
    localparam int CNT_W = $clog2(LIMIT + 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || expired) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired = run && (cnt_q == CNT_W'(LIMIT - 1));

endmodule

// File: rtl/seq_try_counter.sv
module seq_try_counter #(
    parameter int LINK_TRIES = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic last
);

    localparam int TRY_W = $clog2(LINK_TRIES + 1);

    logic [TRY_W-1:0] tries_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tries_q <= '0;
        end else if (clr) begin
            tries_q <= '0;
        end else if (inc) begin
            tries_q <= tries_q + 1'b1;
        end
    end

    assign last = (tries_q >= TRY_W'(LINK_TRIES));

endmodule

// File: rtl/serdes_reconfig_seq.sv
module serdes_reconfig_seq
    import serdes_reconfig_pkg::*;
#(
    parameter int NUM_LANES  = 8,
    parameter int CYC_PER_MS = 200000,
    parameter int HOLD_MS    = 10,
    parameter int LINK_TRIES = 20,
    localparam int LANE_W    = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [LANE_W-1:0]  req_lane,
    input  logic [2:0]         req_mode,
    output logic               req_ready,
    output logic               req_rej,
    output logic               done,
    output logic               err_pll,
    output logic               err_clk,
    output logic               err_link,
    output logic               acc_valid,
    output logic               acc_write,
    output logic [LANE_W-1:0]  lane_sel,
    output logic [2:0]         acc_field,
    output logic [4:0]         acc_wdata,
    input  logic               acc_ready,
    input  logic               acc_rdata,
    output logic               pll_req,
    output logic [2:0]         pll_speed,
    input  logic               pll_done,
    input  logic               pll_err,
    output logic               clk_req,
    input  logic               clk_done,
    input  logic               clk_timeout
);

    seq_state_e state_q, state_d;

    logic               dec_ok, dec_off, dec_10g;
    logic [WDATA_W-1:0] dec_msel;
    logic [SPEED_W-1:0] dec_speed;

    logic [LANE_W-1:0]  lane_q;
    logic [WDATA_W-1:0] msel_q;
    logic [SPEED_W-1:0] speed_q;
    logic               off_q, is10g_q, lb_saved_q, final_q, rej_q;
    logic               e_pll_q, e_clk_q, e_link_q;

    logic accept, acked, hold_run, hold_exp, tries_last, try_inc;

    seq_mode_decode i_decode (
        .code      (req_mode),
        .supported (dec_ok),
        .is_off    (dec_off),
        .is_10g    (dec_10g),
        .mode_sel  (dec_msel),
        .speed     (dec_speed)
    );

    assign hold_run = (state_q == S_SMR_HI) || (state_q == S_SMR_LO);

    seq_hold_timer #(
        .CYC_PER_MS (CYC_PER_MS),
        .HOLD_MS    (HOLD_MS)
    ) i_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (hold_run),
        .expired (hold_exp)
    );

    assign try_inc = (state_q == S_SMR_SET) && acc_ready && !final_q;

    seq_try_counter #(
        .LINK_TRIES (LINK_TRIES)
    ) i_tries (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state_q == S_IDLE),
        .inc   (try_inc),
        .last  (tries_last)
    );

    assign accept = (state_q == S_IDLE) && req_valid && dec_ok;
    assign acked  = acc_valid && acc_ready;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:       if (accept) state_d = S_PWR_DN;
            S_PWR_DN:     if (acked) state_d = S_OFF_FEN;
            S_OFF_FEN:    if (acked) state_d = S_OFF_MODE;
            S_OFF_MODE:   if (acked) state_d = off_q ? S_DONE : S_PLL;
            S_PLL:        if (pll_done) state_d = S_NEW_FEN;
            S_NEW_FEN:    if (acked) state_d = S_NEW_MODE;
            S_NEW_MODE:   if (acked) state_d = S_CLK;
            S_CLK:        if (clk_done) state_d = is10g_q ? S_LB_SAVE : S_PWR_UP;
            S_LB_SAVE:    if (acked) state_d = S_LB_ON;
            S_LB_ON:      if (acked) state_d = S_SMR_SET;
            S_SMR_SET:    if (acked) state_d = S_SMR_HI;
            S_SMR_HI:     if (hold_exp) state_d = S_SMR_CLR;
            S_SMR_CLR:    if (acked) state_d = S_SMR_LO;
            S_SMR_LO:     if (hold_exp) state_d = final_q ? S_PWR_UP : S_LINK_RD1;
            S_LINK_RD1:   if (acked) state_d = S_LINK_RD2;
            S_LINK_RD2: begin
                if (acked) begin
                    state_d = (acc_rdata || tries_last) ? S_LB_RESTORE : S_SMR_SET;
                end
            end
            S_LB_RESTORE: if (acked) state_d = S_SMR_SET;
            S_PWR_UP:     if (acked) state_d = S_RX_SET;
            S_RX_SET:     if (acked) state_d = S_RX_CLR;
            S_RX_CLR:     if (acked) state_d = S_DONE;
            S_DONE:       state_d = S_IDLE;
            default:      state_d = S_IDLE;
        endcase
    end

    // request capture, saved loopback and error flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lane_q     <= '0;
            msel_q     <= MSEL_OFF;
            speed_q    <= SPD_1G;
            off_q      <= 1'b0;
            is10g_q    <= 1'b0;
            lb_saved_q <= 1'b0;
            final_q    <= 1'b0;
            rej_q      <= 1'b0;
            e_pll_q    <= 1'b0;
            e_clk_q    <= 1'b0;
            e_link_q   <= 1'b0;
        end else begin
            rej_q <= (state_q == S_IDLE) && req_valid && !dec_ok;
            if (accept) begin
                lane_q   <= req_lane;
                msel_q   <= dec_msel;
                speed_q  <= dec_speed;
                off_q    <= dec_off;
                is10g_q  <= dec_10g;
                final_q  <= 1'b0;
                e_pll_q  <= 1'b0;
                e_clk_q  <= 1'b0;
                e_link_q <= 1'b0;
            end
            if (state_q == S_PLL && pll_done && pll_err) begin
                e_pll_q <= 1'b1;
            end
            if (state_q == S_CLK && clk_done && clk_timeout) begin
                e_clk_q <= 1'b1;
            end
            if (state_q == S_LB_SAVE && acked) begin
                lb_saved_q <= acc_rdata;
            end
            if (state_q == S_LINK_RD2 && acked && !acc_rdata && tries_last) begin
                e_link_q <= 1'b1;
            end
            if (state_q == S_LB_RESTORE && acked) begin
                final_q <= 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        acc_valid = 1'b1;
        acc_write = 1'b1;
        acc_field = FLD_PWR;
        acc_wdata = '0;
        pll_req   = 1'b0;
        clk_req   = 1'b0;
        done      = 1'b0;
        unique case (state_q)
            S_PWR_DN:     begin acc_field = FLD_PWR;   acc_wdata = PWR_DOWN_VAL; end
            S_OFF_FEN,
            S_NEW_FEN:    begin acc_field = FLD_FEN;   acc_wdata = 5'd1; end
            S_OFF_MODE:   begin acc_field = FLD_MODE;  acc_wdata = MSEL_OFF; end
            S_NEW_MODE:   begin acc_field = FLD_MODE;  acc_wdata = msel_q; end
            S_LB_SAVE:    begin acc_field = FLD_LPBK;  acc_write = 1'b0; end
            S_LB_ON:      begin acc_field = FLD_LPBK;  acc_wdata = 5'd1; end
            S_SMR_SET:    begin acc_field = FLD_SMRST; acc_wdata = 5'd1; end
            S_SMR_CLR:    begin acc_field = FLD_SMRST; acc_wdata = 5'd0; end
            S_LINK_RD1,
            S_LINK_RD2:   begin acc_field = FLD_LINK;  acc_write = 1'b0; end
            S_LB_RESTORE: begin acc_field = FLD_LPBK;  acc_wdata = {4'd0, lb_saved_q}; end
            S_PWR_UP:     begin acc_field = FLD_PWR;   acc_wdata = PWR_UP_VAL; end
            S_RX_SET:     begin acc_field = FLD_RXRST; acc_wdata = 5'd1; end
            S_RX_CLR:     begin acc_field = FLD_RXRST; acc_wdata = 5'd0; end
            S_PLL:        begin acc_valid = 1'b0; pll_req = 1'b1; end
            S_CLK:        begin acc_valid = 1'b0; clk_req = 1'b1; end
            S_DONE:       begin acc_valid = 1'b0; done = 1'b1; end
            S_IDLE,
            S_SMR_HI,
            S_SMR_LO:     begin acc_valid = 1'b0; end
            default:      begin acc_valid = 1'b0; end
        endcase
    end

    assign req_ready = (state_q == S_IDLE);
    assign req_rej   = rej_q;
    assign lane_sel  = lane_q;
    assign pll_speed = speed_q;
    assign err_pll   = e_pll_q;
    assign err_clk   = e_clk_q;
    assign err_link  = e_link_q;

endmodule

// File: rtl/serdes_reconfig_chk.sv
module serdes_reconfig_chk #(
    parameter int LANE_W     = 3,
    parameter int LINK_TRIES = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_rej,
    input logic              done,
    input logic              acc_valid,
    input logic              acc_write,
    input logic [LANE_W-1:0] lane_sel,
    input logic [2:0]        acc_field,
    input logic [4:0]        acc_wdata,
    input logic              acc_ready,
    input logic              pll_req,
    input logic              pll_done,
    input logic              clk_req
);

    localparam int CW = $clog2(LINK_TRIES + 3);

    logic [CW-1:0] smr_sets_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smr_sets_q <= '0;
        end else if (req_valid && req_ready) begin
            smr_sets_q <= '0;
        end else if (acc_valid && acc_ready && acc_write && acc_field == 3'd4 && acc_wdata == 5'd1) begin
            smr_sets_q <= smr_sets_q + 1'b1;
        end
    end

    p_hold_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_ready) |=> (acc_valid && $stable(acc_field) && $stable(acc_wdata)
                                       && $stable(acc_write) && $stable(lane_sel)));

    p_reject_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_rej |-> (!acc_valid && !pll_req && !clk_req));

    p_busy_no_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid || pll_req || clk_req) |-> !req_ready);

    p_pll_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pll_req && !pll_done) |=> pll_req);

    p_done_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> req_ready);

    p_try_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        smr_sets_q <= CW'(LINK_TRIES + 1));

endmodule

bind serdes_reconfig_seq serdes_reconfig_chk #(
    .LANE_W     (LANE_W),
    .LINK_TRIES (LINK_TRIES)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_rej   (req_rej),
    .done      (done),
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .lane_sel  (lane_sel),
    .acc_field (acc_field),
    .acc_wdata (acc_wdata),
    .acc_ready (acc_ready),
    .pll_req   (pll_req),
    .pll_done  (pll_done),
    .clk_req   (clk_req)
);

// File: tb/test_serdes_reconfig_seq.sv
`timescale 1ns/1ps
module test_serdes_reconfig_seq;

    localparam int NL     = 4;
    localparam int CPM    = 2;
    localparam int HMS    = 3;
    localparam int TRIES  = 4;
    localparam int LW     = 2;
    localparam int HOLD   = CPM * HMS;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [LW-1:0] req_lane = '0;
    logic [2:0] req_mode = '0;
    logic req_ready, req_rej, done, err_pll, err_clk, err_link;
    logic acc_valid, acc_write;
    logic [LW-1:0] lane_sel;
    logic [2:0] acc_field;
    logic [4:0] acc_wdata;
    logic acc_ready = 1'b0;
    logic acc_rdata = 1'b0;
    logic pll_req;
    logic [2:0] pll_speed;
    logic pll_done = 1'b0, pll_err = 1'b0;
    logic clk_req;
    logic clk_done = 1'b0, clk_timeout = 1'b0;

    always #2.5 clk = ~clk;

    serdes_reconfig_seq #(
        .NUM_LANES (NL), .CYC_PER_MS (CPM), .HOLD_MS (HMS), .LINK_TRIES (TRIES)
    ) i_serdes_reconfig_seq (
        .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_lane (req_lane),
        .req_mode (req_mode), .req_ready (req_ready), .req_rej (req_rej), .done (done),
        .err_pll (err_pll), .err_clk (err_clk), .err_link (err_link),
        .acc_valid (acc_valid), .acc_write (acc_write), .lane_sel (lane_sel),
        .acc_field (acc_field), .acc_wdata (acc_wdata), .acc_ready (acc_ready),
        .acc_rdata (acc_rdata), .pll_req (pll_req), .pll_speed (pll_speed),
        .pll_done (pll_done), .pll_err (pll_err), .clk_req (clk_req),
        .clk_done (clk_done), .clk_timeout (clk_timeout)
    );

    typedef struct {
        int    kind;   // 0 write, 1 read, 2 pll, 3 clock-ready
        int    lane;
        int    field;
        int    data;
        string rq;
    } item_t;

    item_t exp_q[$];
    int checks = 0;
    int errors = 0;
    int cyc = 0;

    // behavioural register model and companion responders
    bit lb_mem [NL];
    int pulses = 0;
    bit rd_second = 0;
    int cfg_pass_at = 0;
    bit cfg_pll_err = 0, cfg_clk_err = 0;
    int pll_wait = 0, clk_wait = 0;
    int t_smr_set = 0, t_smr_clr = 0;
    bit after_clr = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string rq, input int act, input int exp_v, input string what);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp_v);
        end
    endtask

    task automatic observe(input int kind, input int lane, input int field, input int data);
        item_t e;
        if (exp_q.size() == 0) begin
            check(0, "R11", kind * 100 + field, -1, "unexpected activity");
            return;
        end
        e = exp_q.pop_front();
        check(e.kind == kind, e.rq, kind, e.kind, "kind");
        check(e.lane == lane, e.rq, lane, e.lane, "lane");
        if (kind <= 1) check(e.field == field, e.rq, field, e.field, "field");
        if (kind == 0 || kind == 2) check(e.data == data, e.rq, data, e.data, "data");
    endtask

    always @(negedge clk) begin
        if (acc_valid && !acc_ready) begin
            acc_ready <= 1'b1;
            if (after_clr) begin
                check(cyc - t_smr_clr >= HOLD, "R12", cyc - t_smr_clr, HOLD, "hold after reset clear");
                after_clr = 0;
            end
            if (acc_write) begin
                if (acc_field == 3'd3) lb_mem[lane_sel] = acc_wdata[0];
                if (acc_field == 3'd4) begin
                    rd_second = 0;
                    if (acc_wdata == 5'd1) begin
                        pulses++;
                        t_smr_set = cyc;
                    end else begin
                        check(cyc - t_smr_set >= HOLD, "R12", cyc - t_smr_set, HOLD, "hold after reset set");
                        t_smr_clr = cyc;
                        after_clr = 1;
                    end
                end
            end else begin
                if (acc_field == 3'd3) acc_rdata <= lb_mem[lane_sel];
                else if (acc_field == 3'd5) begin
                    acc_rdata <= rd_second && cfg_pass_at != 0 && pulses >= cfg_pass_at;
                    rd_second = !rd_second;
                end else acc_rdata <= 1'b0;
            end
            observe(acc_write ? 0 : 1, int'(lane_sel), int'(acc_field), int'(acc_wdata));
        end else begin
            acc_ready <= 1'b0;
        end

        if (pll_req && !pll_done) begin
            if (pll_wait == 2) begin
                pll_done <= 1'b1;
                pll_err  <= cfg_pll_err;
                pll_wait = 0;
                observe(2, int'(lane_sel), 0, int'(pll_speed));
            end else pll_wait++;
        end else begin
            pll_done <= 1'b0;
            pll_err  <= 1'b0;
        end

        if (clk_req && !clk_done) begin
            if (clk_wait == 3) begin
                clk_done    <= 1'b1;
                clk_timeout <= cfg_clk_err;
                clk_wait = 0;
                observe(3, int'(lane_sel), 0, 0);
            end else clk_wait++;
        end else begin
            clk_done    <= 1'b0;
            clk_timeout <= 1'b0;
        end
    end

    function automatic int mode_val(input int code);
        case (code)
            1: return 'h02;
            2: return 'h04;
            3: return 'h12;
            4: return 'h16;
            5: return 'h1A;
            default: return 'h1F;
        endcase
    endfunction

    function automatic int speed_val(input int code);
        if (code <= 2) return 1;
        if (code <= 4) return 3;
        return 5;
    endfunction

    task automatic push(input int kind, input int lane, input int field, input int data, input string rq);
        item_t e;
        e.kind = kind; e.lane = lane; e.field = field; e.data = data; e.rq = rq;
        exp_q.push_back(e);
    endtask

    task automatic run_seq(input int lane, input int code, input bit pe, input bit ce,
                           input int pass_at, input bit lb_init, input bit busy_poke);
        int n;
        int guard;
        bit exp_link_err;
        cfg_pll_err = pe; cfg_clk_err = ce; cfg_pass_at = pass_at;
        lb_mem[lane] = lb_init; pulses = 0;
        push(0, lane, 0, 3, "R3");
        push(0, lane, 1, 1, "R3");
        push(0, lane, 2, 'h1F, "R4");
        exp_link_err = 0;
        if (code != 0) begin
            push(2, lane, 0, speed_val(code), "R5");
            push(0, lane, 1, 1, "R3");
            push(0, lane, 2, mode_val(code), "R5");
            push(3, lane, 0, 0, "R3");
            if (code == 5) begin
                push(1, lane, 3, 0, "R6");
                push(0, lane, 3, 1, "R6");
                n = (pass_at != 0 && pass_at <= TRIES) ? pass_at : TRIES;
                exp_link_err = !(pass_at != 0 && pass_at <= TRIES);
                for (int i = 0; i < n; i++) begin
                    push(0, lane, 4, 1, "R6");
                    push(0, lane, 4, 0, "R6");
                    push(1, lane, 5, 0, "R6");
                    push(1, lane, 5, 0, "R7");
                end
                push(0, lane, 3, lb_init, "R8");
                push(0, lane, 4, 1, "R8");
                push(0, lane, 4, 0, "R8");
            end
            push(0, lane, 0, 0, "R3");
            push(0, lane, 6, 1, "R3");
            push(0, lane, 6, 0, "R3");
        end
        @(negedge clk);
        req_valid = 1'b1; req_lane = LW'(lane); req_mode = 3'(code);
        @(negedge clk);
        req_valid = 1'b0;
        if (busy_poke) begin
            repeat (5) @(negedge clk);
            check(req_ready == 1'b0, "R11", req_ready, 0, "ready while busy");
            req_valid = 1'b1; req_lane = LW'((lane + 1) % NL); req_mode = 3'd2;
            repeat (3) @(negedge clk);
            req_valid = 1'b0;
        end
        guard = 0;
        while (!done && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        check(done == 1'b1, "R3", done, 1, "done strobe");
        check(err_pll == pe, "R9", err_pll, pe, "pll error flag");
        check(err_clk == ce, "R9", err_clk, ce, "clock error flag");
        check(err_link == exp_link_err, "R7", err_link, exp_link_err, "link error flag");
        check(exp_q.size() == 0, "R3", exp_q.size(), 0, "items left");
        exp_q.delete();
        @(negedge clk);
        check(req_ready == 1'b1, "R1", req_ready, 1, "idle after done");
    endtask

    task automatic reject(input int code);
        @(negedge clk);
        req_valid = 1'b1; req_mode = 3'(code); req_lane = '0;
        @(negedge clk);
        req_valid = 1'b0;
        check(req_rej == 1'b1, "R2", req_rej, 1, "reject strobe");
        repeat (10) @(negedge clk);
        check(req_ready == 1'b1, "R2", req_ready, 1, "still idle after reject");
        check(req_rej == 1'b0, "R2", req_rej, 0, "reject strobe one cycle");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1, "R1", req_ready, 1, "reset ready");
        check(acc_valid == 1'b0, "R1", acc_valid, 0, "reset access");
        check(done == 1'b0 && req_rej == 1'b0, "R1", done, 0, "reset strobes");
        check(pll_req == 1'b0 && clk_req == 1'b0, "R1", pll_req, 0, "reset handshakes");

        run_seq(1, 1, 0, 0, 0, 0, 0);   // SGMII
        run_seq(2, 0, 0, 0, 0, 0, 0);   // off
        reject(6);
        run_seq(0, 5, 0, 0, 2, 0, 0);   // 10G passes on second attempt
        run_seq(3, 5, 0, 0, 0, 1, 0);   // 10G never links
        run_seq(0, 3, 1, 0, 0, 0, 0);   // HSGMII, PLL error
        run_seq(1, 4, 0, 1, 0, 0, 0);   // 2500BASE-X, clock timeout
        run_seq(2, 2, 0, 0, 0, 0, 1);   // 1000BASE-X with ignored busy request
        reject(7);
        run_seq(3, 5, 0, 0, 1, 1, 0);   // 10G passes at once

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule